// File: doc/BRIEF.md
# Linked Control-Block DMA Channel Sequencer

This block is the control half of one DMA channel. Software writes the address of a control block into the current-block register and sets the active bit. The sequencer then reads the eight-word block from memory, one word per handshake, and loads its working registers. It hands source, destination, length and transfer-info to an external data mover, and waits for the mover to report completion. It then posts end and interrupt status and follows the block's link word. A zero link ends the chain. A link that points back to an earlier block forms a ring that keeps running until software pauses or resets the channel.

Software learns that the channel is idle from a zero current-block address. The active bit stays set after the chain ends, so it does not show idleness. A control/status word gives software three further controls. Writing 0 to the active bit pauses the channel at the next block boundary. A write-only skip bit drops the transfer in flight and moves on to the linked block. A write-only reset bit returns the whole channel to its reset state, even partway through a fetch.

The FSM has five states. IDLE waits for a nonzero block address while active is set. FETCH issues the eight word reads. LAUNCH pulses the mover start and needs active to be set. MOVE waits for mover completion. FINISH posts status and takes the link. The transitions are: IDLE→FETCH (active and address nonzero); FETCH→LAUNCH (eighth word accepted); LAUNCH→MOVE (start issued while active); MOVE→FINISH (mover done); MOVE→IDLE (skip or reset, with a kill pulse to the mover); FINISH→IDLE (always); FETCH/LAUNCH→IDLE (reset write).

Top module: `dmac_chan_seq`

## Requirements
- R1: After rst_n, the control/status word (offset 0x00) reads 0x10, with only the paused bit 4 set. The current-block address (0x04) reads 0, irq is 0 and mem_rd_req is 0.
- R2: A fetch reads addresses base, base+4 … base+28 in that order. Each address and the request stay stable until mem_rd_rdy. Words 0 to 5 load transfer-info, source, destination, length, stride and link. Words 6 and 7 are discarded.
- R3: After each fetch, mv_start pulses for exactly one cycle, with mv_info, mv_src, mv_dst and mv_len taken from the fetched block. mv_len keeps only the low 30 bits of the length word (16 bits when LITE=1).
- R4: When the mover reports done, control/status bit 1 (end) is set and the current-block address takes the link word. Bit 2 (interrupt) and irq are set only if bit 0 of that block's transfer-info is 1.
- R5: While the link is nonzero the next block is fetched without software action. After a block with a zero link, the current-block address reads 0 and active (bit 0) stays 1.
- R6: A control/status write sets active from data bit 0 and clears end or interrupt where data bits 1 or 2 are 1. Writing 0x5 therefore clears the interrupt and keeps the channel active.
- R7: With active set and a current-block address of 0, no memory read and no mv_start occur.
- R8: A link that points to its own block keeps the channel issuing transfers, and the current-block address never reads 0.
- R9: Writing active=0 sets the paused bit 4. The block in flight completes, and no further transfer starts.
- R10: Writing bit 30 while a transfer is in progress pulses mv_kill and loads the link into the current-block address. It sets neither end nor interrupt for the dropped block.
- R11: Writing bit 31 in any state drops mem_rd_req and clears the current-block address, status and irq. A fetch partly done is abandoned. Bits 30 and 31 read back as 0.
- R12: Bit 6 of control/status reflects mv_wr_pend. Offset 0x20 reads bit 28 equal to LITE. Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read back the loaded transfer-info, source, destination, length, stride and link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free reset, sampled on clk |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | RAW | Register write byte offset |
| reg_wr_data | input | DW | Register write data |
| reg_rd_addr | input | RAW | Register read byte offset |
| reg_rd_data | output | DW | Register read data (combinational) |
| mem_rd_req | output | 1 | Descriptor word read request (valid) |
| mem_rd_addr | output | AW | Descriptor word byte address |
| mem_rd_rdy | input | 1 | Memory accepts request; data valid this cycle |
| mem_rd_data | input | DW | Descriptor word data |
| mv_start | output | 1 | One-cycle start pulse to the data mover |
| mv_info | output | DW | Transfer-info word for the mover |
| mv_src | output | AW | Source address |
| mv_dst | output | AW | Destination address |
| mv_len | output | DW | Transfer length in bytes |
| mv_kill | output | 1 | Cancel the transfer in flight |
| mv_done | input | 1 | Mover finished the current transfer |
| mv_wr_pend | input | 1 | Mover still has unacknowledged writes |
| irq | output | 1 | Interrupt status |

## Verification
The hardest cases arise while the channel is busy inside a block. These are a reset write that lands between descriptor beats, and a skip that lands during a long transfer. The bench reaches the first by holding the memory's ready low after a fetch starts, so the channel sits in FETCH. It reaches the second with a mover model whose completion delay is lengthened before the block and shortened again for the following one. A self-linked ring is stopped by a pause written right after a counted number of starts, and the mover delay is long enough that the pause lands before the next fetch.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LAUNCH,
        ST_MOVE,
        ST_FINISH
    } seq_state_e;

    localparam int CB_WORDS = 8;
    localparam int CB_IDX_W = $clog2(CB_WORDS);

    // word positions inside a control block (fixed by the memory layout)
    localparam int W_INFO   = 0;
    localparam int W_SRC    = 1;
    localparam int W_DST    = 2;
    localparam int W_LEN    = 3;
    localparam int W_STRIDE = 4;
    localparam int W_NEXT   = 5;

    // register byte offsets
    localparam logic [5:0] RA_CS     = 6'h00;
    localparam logic [5:0] RA_CB     = 6'h04;
    localparam logic [5:0] RA_INFO   = 6'h08;
    localparam logic [5:0] RA_SRC    = 6'h0C;
    localparam logic [5:0] RA_DST    = 6'h10;
    localparam logic [5:0] RA_LEN    = 6'h14;
    localparam logic [5:0] RA_STRIDE = 6'h18;
    localparam logic [5:0] RA_NEXT   = 6'h1C;
    localparam logic [5:0] RA_DBG    = 6'h20;

    // control/status bit positions
    localparam int CS_ACTIVE = 0;
    localparam int CS_END    = 1;
    localparam int CS_INT    = 2;
    localparam int CS_PAUSED = 4;
    localparam int CS_WAITWR = 6;
    localparam int CS_SKIP   = 30;
    localparam int CS_RESET  = 31;
    localparam int DBG_LITE  = 28;
    localparam int INFO_IEN  = 0;
endpackage

// File: rtl/dmac_cb_fetch.sv
module dmac_cb_fetch
    import dmac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                flush,
    input  logic [AW-1:0]       base,
    input  logic                mem_rd_rdy,
    output logic                mem_rd_req,
    output logic [AW-1:0]       mem_rd_addr,
    output logic                cap_en,
    output logic [CB_IDX_W-1:0] cap_idx,
    output logic                last
);
    localparam logic [CB_IDX_W-1:0] IDX_LAST = CB_IDX_W'(CB_WORDS - 1);

    logic [CB_IDX_W-1:0] idx_q;
    logic                hs;

    assign mem_rd_req  = go;
    assign hs          = go && mem_rd_rdy && !flush;
    assign mem_rd_addr = base + {{(AW-CB_IDX_W-2){1'b0}}, idx_q, 2'b00};
    assign cap_en      = hs;
    assign cap_idx     = idx_q;
    assign last        = hs && (idx_q == IDX_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            idx_q <= '0;
        end else if (hs) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/dmac_seq_fsm.sv
module dmac_seq_fsm
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       cb_nz,
    input  logic       fetch_last,
    input  logic       mv_done,
    input  logic       skip_req,
    input  logic       soft_rst,
    output seq_state_e state_q,
    output logic       fetch_go,
    output logic       mv_start,
    output logic       mv_kill,
    output logic       blk_done,
    output logic       skip
);
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        fetch_go = 1'b0;
        mv_start = 1'b0;
        mv_kill  = 1'b0;
        blk_done = 1'b0;
        skip     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!soft_rst && active && cb_nz) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                fetch_go = 1'b1;
                if (soft_rst)        state_d = ST_IDLE;
                else if (fetch_last) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                if (soft_rst) begin
                    state_d = ST_IDLE;
                end else if (active) begin
                    mv_start = 1'b1;
                    state_d  = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (soft_rst) begin
                    mv_kill = 1'b1;
                    state_d = ST_IDLE;
                end else if (skip_req) begin
                    mv_kill = 1'b1;
                    skip    = 1'b1;
                    state_d = ST_IDLE;
                end else if (mv_done) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                blk_done = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dmac_chan_seq.sv
module dmac_chan_seq
    import dmac_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int RAW  = 6,
    parameter bit LITE = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr_en,
    input  logic [RAW-1:0] reg_wr_addr,
    input  logic [DW-1:0]  reg_wr_data,
    input  logic [RAW-1:0] reg_rd_addr,
    output logic [DW-1:0]  reg_rd_data,
    output logic           mem_rd_req,
    output logic [AW-1:0]  mem_rd_addr,
    input  logic           mem_rd_rdy,
    input  logic [DW-1:0]  mem_rd_data,
    output logic           mv_start,
    output logic [DW-1:0]  mv_info,
    output logic [AW-1:0]  mv_src,
    output logic [AW-1:0]  mv_dst,
    output logic [DW-1:0]  mv_len,
    output logic           mv_kill,
    input  logic           mv_done,
    input  logic           mv_wr_pend,
    output logic           irq
);
    localparam int LEN_W = LITE ? 16 : 30;

    seq_state_e          state_q;
    logic                act_q, end_q, int_q;
    logic [AW-1:0]       cb_q, src_q, dst_q, next_q;
    logic [DW-1:0]       info_q, stride_q;
    logic [LEN_W-1:0]    len_q;
    logic                cs_wr, soft_rst, skip_req, cb_wr;
    logic                fetch_go, fetch_last, cap_en, blk_done, skip;
    logic [CB_IDX_W-1:0] cap_idx;

    assign cs_wr    = reg_wr_en && (reg_wr_addr == RAW'(RA_CS));
    assign soft_rst = cs_wr && reg_wr_data[CS_RESET];
    assign skip_req = cs_wr && reg_wr_data[CS_SKIP] && !reg_wr_data[CS_RESET];

    dmac_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (act_q),
        .cb_nz      (cb_q != '0),
        .fetch_last (fetch_last),
        .mv_done    (mv_done),
        .skip_req   (skip_req),
        .soft_rst   (soft_rst),
        .state_q    (state_q),
        .fetch_go   (fetch_go),
        .mv_start   (mv_start),
        .mv_kill    (mv_kill),
        .blk_done   (blk_done),
        .skip       (skip)
    );

    dmac_cb_fetch #(.AW(AW)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (fetch_go),
        .flush       (soft_rst),
        .base        (cb_q),
        .mem_rd_rdy  (mem_rd_rdy),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .cap_en      (cap_en),
        .cap_idx     (cap_idx),
        .last        (fetch_last)
    );

    assign cb_wr = reg_wr_en && (reg_wr_addr == RAW'(RA_CB)) && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            act_q <= 1'b0;
            end_q <= 1'b0;
            int_q <= 1'b0;
        end else begin
            if (cs_wr) begin
                act_q <= reg_wr_data[CS_ACTIVE];
                if (reg_wr_data[CS_END]) end_q <= 1'b0;
                if (reg_wr_data[CS_INT]) int_q <= 1'b0;
            end
            if (blk_done) begin
                end_q <= 1'b1;
                if (info_q[INFO_IEN]) int_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)    cb_q <= '0;
        else if (blk_done || skip) cb_q <= next_q;
        else if (cb_wr)            cb_q <= AW'(reg_wr_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            info_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            len_q    <= '0;
            stride_q <= '0;
            next_q   <= '0;
        end else if (cap_en) begin
            case (int'(cap_idx))
                W_INFO:   info_q   <= mem_rd_data;
                W_SRC:    src_q    <= AW'(mem_rd_data);
                W_DST:    dst_q    <= AW'(mem_rd_data);
                W_LEN:    len_q    <= mem_rd_data[LEN_W-1:0];
                W_STRIDE: stride_q <= mem_rd_data;
                W_NEXT:   next_q   <= AW'(mem_rd_data);
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rd_data = '0;
        case (reg_rd_addr)
            RAW'(RA_CS): begin
                reg_rd_data[CS_ACTIVE] = act_q;
                reg_rd_data[CS_END]    = end_q;
                reg_rd_data[CS_INT]    = int_q;
                reg_rd_data[CS_PAUSED] = !act_q;
                reg_rd_data[CS_WAITWR] = mv_wr_pend;
            end
            RAW'(RA_CB):     reg_rd_data = DW'(cb_q);
            RAW'(RA_INFO):   reg_rd_data = info_q;
            RAW'(RA_SRC):    reg_rd_data = DW'(src_q);
            RAW'(RA_DST):    reg_rd_data = DW'(dst_q);
            RAW'(RA_LEN):    reg_rd_data = DW'(len_q);
            RAW'(RA_STRIDE): reg_rd_data = stride_q;
            RAW'(RA_NEXT):   reg_rd_data = DW'(next_q);
            RAW'(RA_DBG):    reg_rd_data[DBG_LITE] = LITE;
            default:         reg_rd_data = '0;
        endcase
    end

    assign mv_info = info_q;
    assign mv_src  = src_q;
    assign mv_dst  = dst_q;
    assign mv_len  = DW'(len_q);
    assign irq     = int_q;
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int RAW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr_en,
    input logic [RAW-1:0] reg_wr_addr,
    input logic [DW-1:0]  reg_wr_data,
    input logic           mem_rd_req,
    input logic           mem_rd_rdy,
    input logic [AW-1:0]  mem_rd_addr,
    input logic           mv_start,
    input logic           mv_done,
    input logic           mv_kill,
    input logic           irq,
    input logic [AW-1:0]  cb_q
);
    logic rst_wr;
    assign rst_wr = reg_wr_en && (reg_wr_addr == '0) && reg_wr_data[DW-1];

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_rdy && !rst_wr) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);

    // R4
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mv_done, 2));

    // R7
    start_needs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> (cb_q != '0));

    // R10
    kill_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_kill |=> !mv_start);

    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (!mem_rd_req && (cb_q == '0) && !irq));
endmodule

bind dmac_chan_seq dmac_chan_chk #(.AW(AW), .DW(DW), .RAW(RAW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_rdy  (mem_rd_rdy),
    .mem_rd_addr (mem_rd_addr),
    .mv_start    (mv_start),
    .mv_done     (mv_done),
    .mv_kill     (mv_kill),
    .irq         (irq),
    .cb_q        (cb_q)
);

// File: tb/test_dmac_chan_seq.sv
module test_dmac_chan_seq;
    typedef struct {
        logic [31:0] info;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [5:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_rdy;
    logic [31:0] mem_rd_data;
    logic        mv_start, mv_kill, irq;
    logic [31:0] mv_info, mv_src, mv_dst, mv_len;
    logic        mv_done = 1'b0;
    logic        mv_wr_pend = 1'b0;

    logic [31:0] mem [64];
    int          rdy_mode = 0;
    logic        tog = 1'b0;
    xfer_t       exp_q[$];
    int          n_chk = 0, n_fail = 0, n_started = 0, n_kill = 0;
    int          mv_delay = 3;

    always #5 clk = ~clk;

    dmac_chan_seq i_dmac_chan_seq (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_rdy(mem_rd_rdy), .mem_rd_data(mem_rd_data),
        .mv_start(mv_start), .mv_info(mv_info), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_len(mv_len), .mv_kill(mv_kill), .mv_done(mv_done),
        .mv_wr_pend(mv_wr_pend), .irq(irq)
    );

    assign mem_rd_data = mem[mem_rd_addr[7:2]];
    assign mem_rd_rdy  = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? tog : 1'b0;
    always @(negedge clk) tog <= ~tog;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor and data-mover model, sampled just before each rising edge
    always begin
        @(negedge clk);
        #4;
        mv_done = 1'b0;
        if (rst_n) begin
            if (mv_kill) n_kill++;
            if (mv_start) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected start", mv_src, 32'h0);
                end else begin
                    xfer_t e;
                    e = exp_q.pop_front();
                    chk(mv_info == e.info && mv_src == e.src && mv_dst == e.dst && mv_len == e.len,
                        "R3 transfer fields", mv_src ^ mv_len, e.src ^ e.len);
                    n_started++;
                end
            end
            if (mv_kill) mv_cnt = 0;
            else if (mv_start) mv_cnt = mv_delay;
            else if (mv_cnt > 0) begin
                mv_cnt--;
                if (mv_cnt == 0) mv_done = 1'b1;
            end
        end
    end
    int mv_cnt = 0;

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd_addr = a;
        #1 v = reg_rd_data;
    endtask

    task automatic put_blk(input int b, input logic [31:0] info, src, dst, len, stride, nxt);
        mem[b/4+0] = info; mem[b/4+1] = src; mem[b/4+2] = dst; mem[b/4+3] = len;
        mem[b/4+4] = stride; mem[b/4+5] = nxt; mem[b/4+6] = 32'hDEAD0006; mem[b/4+7] = 32'hDEAD0007;
    endtask

    task automatic push(input logic [31:0] info, src, dst, len);
        xfer_t e;
        e.info = info; e.src = src; e.dst = dst; e.len = len;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(6'h04, v);
            if (v == 0) return;
        end
        chk(1'b0, "R5 channel never idle", v, 32'h0);
    endtask

    task automatic wait_starts(input int target);
        for (int i = 0; i < 3000 && n_started < target; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base_n;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        put_blk(32'h40, 32'h0000_0100, 32'h1000, 32'h2000, 32'h40, 32'h11, 32'h60);
        put_blk(32'h60, 32'h0000_0011, 32'h3000, 32'h4000, 32'hFFFF_FFFF, 32'h22, 32'h0);
        put_blk(32'h80, 32'h0000_0001, 32'h5000, 32'h6000, 32'h80, 32'h0, 32'h80);
        put_blk(32'hC0, 32'h0000_0001, 32'h7000, 32'h7800, 32'h100, 32'h0, 32'hE0);
        put_blk(32'hE0, 32'h0000_0000, 32'h8000, 32'h8800, 32'h20, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, v); chk(v == 32'h10, "R1 cs after reset", v, 32'h10);
        rd(6'h04, v); chk(v == 32'h0, "R1 block address after reset", v, 32'h0);
        chk(irq == 1'b0 && mem_rd_req == 1'b0, "R1 irq/req idle", {irq, mem_rd_req}, 32'h0);

        // R2 R3 R4 R5: two-block chain with stalling memory
        rdy_mode = 1;
        push(32'h0000_0100, 32'h1000, 32'h2000, 32'h40);
        push(32'h0000_0011, 32'h3000, 32'h4000, 32'h3FFF_FFFF);
        wr(6'h04, 32'h40);
        wr(6'h00, 32'h1);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(n_started == 2, "R5 chain block count", n_started, 2);
        rd(6'h00, v); chk(v == 32'h7, "R4 end+int, R5 active kept", v, 32'h7);
        chk(irq == 1'b1, "R4 irq after enabled block", irq, 1);
        rd(6'h08, v); chk(v == 32'h11, "R12 info readback", v, 32'h11);
        rd(6'h14, v); chk(v == 32'h3FFF_FFFF, "R3 length width", v, 32'h3FFF_FFFF);
        rd(6'h18, v); chk(v == 32'h22, "R2 stride word", v, 32'h22);
        rd(6'h1C, v); chk(v == 32'h0, "R12 link readback", v, 32'h0);
        rd(6'h10, v); chk(v == 32'h4000, "R12 destination readback", v, 32'h4000);
        rdy_mode = 0;

        // R6 clear interrupt, keep active; R7 no action at zero address
        wr(6'h00, 32'h5);
        rd(6'h00, v); chk(v == 32'h3, "R6 int cleared active kept", v, 32'h3);
        chk(irq == 1'b0, "R6 irq cleared", irq, 0);
        base_n = n_started;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_rd_req) chk(1'b0, "R7 read at zero address", mem_rd_addr, 32'h0);
        end
        chk(n_started == base_n, "R7 no start at zero address", n_started, base_n);

        // R12 waiting-for-writes and debug word
        mv_wr_pend = 1'b1;
        rd(6'h00, v); chk(v == 32'h43, "R12 waiting bit", v, 32'h43);
        mv_wr_pend = 1'b0;
        rd(6'h20, v); chk(v == 32'h0, "R12 lite flag", v, 32'h0);

        // R8 ring, R9 pause, R11 reset
        mv_delay = 6;
        base_n = n_started;
        for (int i = 0; i < 3; i++) push(32'h1, 32'h5000, 32'h6000, 32'h80);
        wr(6'h04, 32'h80);
        wait_starts(base_n + 3);
        wr(6'h00, 32'h0);
        for (int i = 0; i < 40; i++) begin
            rd(6'h04, v);
            if (v == 0) chk(1'b0, "R8 ring reached zero", v, 32'h80);
        end
        chk(n_started == base_n + 3, "R9 no start while paused", n_started, base_n + 3);
        rd(6'h04, v); chk(v == 32'h80, "R8 ring address held", v, 32'h80);
        rd(6'h00, v); chk(v == 32'h16, "R9 paused bit set", v, 32'h16);
        wr(6'h00, 32'h8000_0000);
        rd(6'h00, v); chk(v == 32'h10, "R11 cs after reset write", v, 32'h10);
        rd(6'h04, v); chk(v == 32'h0, "R11 address cleared", v, 32'h0);
        chk(irq == 1'b0, "R11 irq cleared", irq, 0);

        // R10 skip during a long transfer
        mv_delay = 50;
        base_n = n_started;
        push(32'h1, 32'h7000, 32'h7800, 32'h100);
        push(32'h0, 32'h8000, 32'h8800, 32'h20);
        wr(6'h04, 32'hC0);
        wr(6'h00, 32'h1);
        wait_starts(base_n + 1);
        repeat (3) @(negedge clk);
        mv_delay = 2;
        wr(6'h00, 32'h4000_0001);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(n_kill == 1, "R10 kill pulse", n_kill, 1);
        chk(n_started == base_n + 2, "R10 next block ran", n_started, base_n + 2);
        rd(6'h00, v); chk(v == 32'h3, "R10 no int from dropped block", v, 32'h3);

        // R11 reset partway through a fetch
        rdy_mode = 2;
        base_n = n_started;
        wr(6'h04, 32'h40);
        repeat (5) @(negedge clk);
        #1;
        chk(mem_rd_req == 1'b1 && mem_rd_addr == 32'h40, "R2 stalled request held", mem_rd_addr, 32'h40);
        wr(6'h00, 32'h8000_0000);
        #1;
        chk(mem_rd_req == 1'b0, "R11 fetch abandoned", mem_rd_req, 0);
        rd(6'h04, v); chk(v == 32'h0, "R11 address after mid-fetch reset", v, 32'h0);
        rdy_mode = 0;
        repeat (10) @(negedge clk);
        chk(n_started == base_n, "R11 no start after abandon", n_started, base_n);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule